// File: doc/BRIEF.md
# ECC-Protected True Dual-Port RAM

This block is a synchronous RAM with two fully independent ports, A and B, each able to read or write any word in any cycle. The storage array itself has no protection. Error correction is added around it instead. Each port has its own encoder, which turns the 8-bit user word into a 13-bit single-error-correcting, double-error-detecting Hamming codeword before it is stored. Each port also has its own decoder, which checks the codeword it reads, repairs a single flipped bit and reports how clean the word was.

Port A has a test input that inverts codeword bit 0 on its way into the array. This gives a controlled single-bit fault, so a system can exercise the correction path. The behaviour when a read and a write meet in the same cycle is fixed for both cases: the same port, and the other port. When both ports write one address in the same cycle, the result is also defined.

Top module: `ecc_tdp_ram`

## Requirements
- R1: While `rst_n` is low at a clock edge, both read-data outputs become 0 and both status outputs become 00.
- R2: A byte written through either port is later read back unchanged through either port, with status 00.
- R3: A cycle in which a port's write enable is low leaves the stored word unchanged, whatever its address and write data are.
- R4: While a port's read enable is low, that port's read data and status hold their previous values.
- R5: A read has one cycle of latency. Data and status for a read enabled at one clock edge appear together after that edge and stay until the next read.
- R6: A port A write with `a_flip_lsb` high stores the codeword with bit 0 inverted. A later read of that word returns the original byte with status 01. A later clean write to that address makes the status 00 again.
- R7: Codeword bit i-1 holds Hamming position i, for i from 1 to 12. Check bits sit at positions 1, 2, 4 and 8. Data bits d0 to d7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12. Bit 12 makes the parity of all 13 bits even. The decoder returns the byte with status 00 for a clean codeword. For a codeword with any one bit inverted, it returns the original byte with status 01.
- R8: For a codeword with two bits inverted, the decoder reports status 10. Its data output then carries the data-position bits of the received word, uncorrected.
- R9: A port that reads and writes in the same cycle returns the byte it is writing in that cycle.
- R10: A port that reads an address the other port writes in the same cycle returns the word stored before that write.
- R11: When both ports write the same address in the same cycle, port A's word is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset of the read outputs |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | 8 | Port A write byte |
| a_we | input | 1 | Port A write enable |
| a_re | input | 1 | Port A read enable |
| a_flip_lsb | input | 1 | Invert codeword bit 0 of a port A write |
| a_rdata | output | 8 | Port A decoded read byte |
| a_status | output | 2 | Port A status: 00 clean, 01 corrected, 10 uncorrectable |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | 8 | Port B write byte |
| b_we | input | 1 | Port B write enable |
| b_re | input | 1 | Port B read enable |
| b_rdata | output | 8 | Port B decoded read byte |
| b_status | output | 2 | Port B status: 00 clean, 01 corrected, 10 uncorrectable |

## Verification
A wrong stored codeword has two visible effects. It shows as a wrong byte or a non-zero status on the next read of that address, one cycle after the read enable. It can also show as a correction status on a word that was written cleanly. A wrong codeword layout in the encoder or decoder shows at once: the unit-level decoder vectors fail, and clean writes read back with status 01 or 10. A wrong choice of old or new data in the read register shows in the very cycle after a same-address collision. A wrong winner when both ports write shows on the next read of that address.

// File: rtl/ecc_tdp_pkg.sv
// Shared widths, status codes and codeword layout helpers for the ECC RAM.
// Assumes an 8-bit byte with 4 Hamming check bits and one overall parity bit.
package ecc_tdp_pkg;
    localparam int DATA_W = 8;
    localparam int PAR_W  = 4;
    localparam int HAM_W  = DATA_W + PAR_W;
    localparam int CODE_W = HAM_W + 1;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_FIXED = 2'b01,
        ST_FATAL = 2'b10
    } ecc_status_e;

    // True when Hamming position p (1-based) is a check-bit slot.
    function automatic logic is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Hamming position (1-based) that carries data bit k.
    function automatic int data_pos(input int k);
        int r;
        int cnt;
        r   = 0;
        cnt = 0;
        for (int p = 1; p <= HAM_W; p++) begin
            if (!is_pow2(p)) begin
                if (cnt == k) r = p;
                cnt++;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/ecc_enc.sv
// SECDED encoder: places data bits in non-power-of-two positions, computes
// the check bits and appends even overall parity as the top codeword bit.
// Assumes codeword bit i-1 holds Hamming position i.
module ecc_enc
    import ecc_tdp_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);
    logic [HAM_W-1:0] ham;
    logic             par;

    // Build the Hamming word, then add overall parity.
    always_comb begin
        ham = '0;
        for (int k = 0; k < DATA_W; k++) begin
            ham[data_pos(k)-1] = data_i[k];
        end
        for (int j = 0; j < PAR_W; j++) begin
            par = 1'b0;
            for (int p = 1; p <= HAM_W; p++) begin
                if (p[j] && !is_pow2(p)) par = par ^ ham[p-1];
            end
            ham[(1 << j) - 1] = par;
        end
        code_o = {^ham, ham};
    end
endmodule

// File: rtl/ecc_dec.sv
// SECDED decoder: forms the syndrome and the overall parity, flips the single
// bad bit when exactly one is implied, and reports clean / fixed / fatal.
// On a fatal word the raw data-position bits are passed through.
module ecc_dec
    import ecc_tdp_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] data_o,
    output logic [1:0]        status_o
);
    logic [PAR_W-1:0] syn;
    logic             ovp;
    logic [HAM_W-1:0] fixed;
    ecc_status_e      st;

    // Syndrome: parity over each position group, including its check bit.
    always_comb begin
        syn = '0;
        for (int j = 0; j < PAR_W; j++) begin
            for (int p = 1; p <= HAM_W; p++) begin
                if (p[j]) syn[j] = syn[j] ^ code_i[p-1];
            end
        end
        ovp = ^code_i;
    end

    // Correction: invert the position named by the syndrome on odd parity.
    always_comb begin
        fixed = code_i[HAM_W-1:0];
        if (ovp) begin
            for (int p = 1; p <= HAM_W; p++) begin
                if (int'(syn) == p) fixed[p-1] = ~fixed[p-1];
            end
        end
    end

    // Classification: even parity with zero syndrome is clean, odd parity
    // with a reachable syndrome is one error, anything else is fatal.
    always_comb begin
        if (!ovp && syn == '0)               st = ST_CLEAN;
        else if (ovp && int'(syn) <= HAM_W)  st = ST_FIXED;
        else                                 st = ST_FATAL;
    end

    // Data extraction from the corrected or, when fatal, the raw word.
    always_comb begin
        for (int k = 0; k < DATA_W; k++) begin
            data_o[k] = (st == ST_FATAL) ? code_i[data_pos(k)-1]
                                         : fixed[data_pos(k)-1];
        end
        status_o = st;
    end
endmodule

// File: rtl/tdp_array.sv
// Two-port codeword storage with registered read outputs.
// Same-port read during write returns the word being written; a read of an
// address the other port writes returns the old content; on a same-address
// double write port A lands last. The array itself is not reset.
module tdp_array #(
    parameter int ADDR_W = 4,
    parameter int WORD_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [WORD_W-1:0] a_wcode,
    input  logic              a_we,
    input  logic              a_re,
    output logic [WORD_W-1:0] a_rcode,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [WORD_W-1:0] b_wcode,
    input  logic              b_we,
    input  logic              b_re,
    output logic [WORD_W-1:0] b_rcode
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Array writes: B first, A second, so A wins on a shared address.
    always_ff @(posedge clk) begin
        if (b_we) mem[b_addr] <= b_wcode;
        if (a_we) mem[a_addr] <= a_wcode;
    end

    // Port A read register: own write forwarded, otherwise pre-edge content.
    always_ff @(posedge clk) begin
        if (!rst_n)    a_rcode <= '0;
        else if (a_re) a_rcode <= a_we ? a_wcode : mem[a_addr];
    end

    // Port B read register: own write forwarded, otherwise pre-edge content.
    always_ff @(posedge clk) begin
        if (!rst_n)    b_rcode <= '0;
        else if (b_re) b_rcode <= b_we ? b_wcode : mem[b_addr];
    end
endmodule

// File: rtl/ecc_tdp_ram.sv
// ECC-protected true dual-port RAM: one encoder and one decoder per port
// around an unprotected codeword array, plus a port A fault-injection input
// that inverts codeword bit 0 of a write. Read latency is one cycle.
module ecc_tdp_ram
    import ecc_tdp_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_we,
    input  logic              a_re,
    input  logic              a_flip_lsb,
    output logic [DATA_W-1:0] a_rdata,
    output logic [1:0]        a_status,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_we,
    input  logic              b_re,
    output logic [DATA_W-1:0] b_rdata,
    output logic [1:0]        b_status
);
    localparam int NPORT = 2;

    logic [DATA_W-1:0] wd_p  [NPORT];
    logic [CODE_W-1:0] enc_p [NPORT];
    logic [CODE_W-1:0] wc_p  [NPORT];
    logic [CODE_W-1:0] rc_p  [NPORT];
    logic [DATA_W-1:0] rd_p  [NPORT];
    logic [1:0]        st_p  [NPORT];
    logic [CODE_W-1:0] inj_p [NPORT];

    // Port gathering: only port A carries the fault-injection mask.
    always_comb begin
        wd_p[0]  = a_wdata;
        wd_p[1]  = b_wdata;
        inj_p[0] = {{(CODE_W-1){1'b0}}, a_flip_lsb};
        inj_p[1] = '0;
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        ecc_enc u_enc (
            .data_i (wd_p[g]),
            .code_o (enc_p[g])
        );

        // Fault injection on the stored codeword.
        always_comb wc_p[g] = enc_p[g] ^ inj_p[g];

        ecc_dec u_dec (
            .code_i   (rc_p[g]),
            .data_o   (rd_p[g]),
            .status_o (st_p[g])
        );
    end

    tdp_array #(
        .ADDR_W (ADDR_W),
        .WORD_W (CODE_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_addr  (a_addr),
        .a_wcode (wc_p[0]),
        .a_we    (a_we),
        .a_re    (a_re),
        .a_rcode (rc_p[0]),
        .b_addr  (b_addr),
        .b_wcode (wc_p[1]),
        .b_we    (b_we),
        .b_re    (b_re),
        .b_rcode (rc_p[1])
    );

    // Output fan-out of the decoded ports.
    always_comb begin
        a_rdata  = rd_p[0];
        a_status = st_p[0];
        b_rdata  = rd_p[1];
        b_status = st_p[1];
    end
endmodule

// File: rtl/ecc_tdp_ram_chk.sv
// Port-level properties of the ECC dual-port RAM, attached by bind.
module ecc_tdp_ram_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] a_wdata,
    input logic       a_we,
    input logic       a_re,
    input logic       a_flip_lsb,
    input logic [7:0] a_rdata,
    input logic [1:0] a_status,
    input logic [7:0] b_wdata,
    input logic       b_we,
    input logic       b_re,
    input logic [7:0] b_rdata,
    input logic [1:0] b_status
);
    // R9: port A read-during-write returns the written byte.
    p_same_port_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we && a_re) |=> (a_rdata == $past(a_wdata)));

    // R9: port B read-during-write returns the written byte, clean.
    p_same_port_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (b_we && b_re) |=> (b_rdata == $past(b_wdata) && b_status == 2'b00));

    // R6: an injected fault seen on the same port is reported as corrected.
    p_flip_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we && a_re && a_flip_lsb) |=> (a_status == 2'b01));

    // R4: port A outputs hold without a read.
    p_hold_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !a_re |=> ($stable(a_rdata) && $stable(a_status)));

    // R4: port B outputs hold without a read.
    p_hold_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !b_re |=> ($stable(b_rdata) && $stable(b_status)));
endmodule

bind ecc_tdp_ram ecc_tdp_ram_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_wdata    (a_wdata),
    .a_we       (a_we),
    .a_re       (a_re),
    .a_flip_lsb (a_flip_lsb),
    .a_rdata    (a_rdata),
    .a_status   (a_status),
    .b_wdata    (b_wdata),
    .b_we       (b_we),
    .b_re       (b_re),
    .b_rdata    (b_rdata),
    .b_status   (b_status)
);

// File: tb/ecc_tdp_ram_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the step task drives both ports for one cycle and queues
// the expected reads; a negedge monitor pops and compares them when due.
module ecc_tdp_ram_tb;
    localparam int AW = 4;

    typedef struct {
        int         due;
        bit         port;
        logic [7:0] d;
        logic [1:0] st;
        string      tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [7:0]    a_wdata = '0, b_wdata = '0;
    logic          a_we = 1'b0, a_re = 1'b0, a_flip_lsb = 1'b0;
    logic          b_we = 1'b0, b_re = 1'b0;
    logic [7:0]    a_rdata, b_rdata;
    logic [1:0]    a_status, b_status;

    logic [12:0]   ut_code = '0;
    logic [7:0]    ut_data;
    logic [1:0]    ut_status;

    int    vectors = 0;
    int    miscompares = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    item_t sb[$];
    item_t it;

    logic [7:0] m_d [16];
    bit         m_c [16];
    logic [7:0] last_a_d = '0, last_b_d = '0;
    logic [1:0] last_a_s = '0, last_b_s = '0;

    always #4 clk = ~clk;

    ecc_tdp_ram #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_re(a_re),
        .a_flip_lsb(a_flip_lsb), .a_rdata(a_rdata), .a_status(a_status),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_re(b_re),
        .b_rdata(b_rdata), .b_status(b_status)
    );

    ecc_dec u_dec_ut (.code_i(ut_code), .data_o(ut_data), .status_o(ut_status));

    task automatic chk(input string tag, input logic [7:0] ad, input logic [7:0] ed,
                       input logic [1:0] as, input logic [1:0] es);
        vectors++;
        if (ad !== ed || as !== es) begin
            miscompares++;
            $display("FAIL %s: data %h status %b, expected data %h status %b",
                     tag, ad, as, ed, es);
        end
    endtask

    // Reference encoder written from the codeword layout in R7.
    function automatic logic [12:0] tb_enc(input logic [7:0] d);
        logic [12:0] h;
        h = '0;
        h[2] = d[0]; h[4] = d[1]; h[5] = d[2]; h[6] = d[3];
        h[8] = d[4]; h[9] = d[5]; h[10] = d[6]; h[11] = d[7];
        h[0] = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
        h[1] = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
        h[3] = d[1] ^ d[2] ^ d[3] ^ d[7];
        h[7] = d[4] ^ d[5] ^ d[6] ^ d[7];
        h[12] = ^h[11:0];
        return h;
    endfunction

    function automatic logic [7:0] tb_raw(input logic [12:0] c);
        return {c[11], c[10], c[9], c[8], c[6], c[5], c[4], c[2]};
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every expected read that has come due.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            it = sb.pop_front();
            if (it.port == 1'b0) chk(it.tag, a_rdata, it.d, a_status, it.st);
            else                 chk(it.tag, b_rdata, it.d, b_status, it.st);
        end
    end

    // Driver: one cycle on both ports, expected results pushed to the queue.
    task automatic step(input logic [AW-1:0] aa, input logic [7:0] awd,
                        input bit awe, input bit are, input bit aflip,
                        input logic [AW-1:0] ba, input logic [7:0] bwd,
                        input bit bwe, input bit bre, input string tag);
        item_t ia, ib;
        @(negedge clk);
        a_addr = aa; a_wdata = awd; a_we = awe; a_re = are; a_flip_lsb = aflip;
        b_addr = ba; b_wdata = bwd; b_we = bwe; b_re = bre;
        if (are) begin
            last_a_d = awe ? awd : m_d[aa];
            last_a_s = (awe ? aflip : m_c[aa]) ? 2'b01 : 2'b00;
        end
        if (bre) begin
            last_b_d = bwe ? bwd : m_d[ba];
            last_b_s = bwe ? 2'b00 : (m_c[ba] ? 2'b01 : 2'b00);
        end
        ia = '{cyc + 1, 1'b0, last_a_d, last_a_s, are ? tag : "R4"};
        ib = '{cyc + 1, 1'b1, last_b_d, last_b_s, bre ? tag : "R4"};
        sb.push_back(ia);
        sb.push_back(ib);
        if (bwe) begin m_d[ba] = bwd; m_c[ba] = 1'b0; end
        if (awe) begin m_d[aa] = awd; m_c[aa] = aflip; end
    endtask

    task automatic idle();
        step('0, 8'h00, 0, 0, 0, '0, 8'h00, 0, 0, "R4");
    endtask

    initial begin
        // R7 and R8: decoder vectors built from the stated layout.
        foreach (m_d[i]) begin m_d[i] = '0; m_c[i] = 1'b0; end
        for (int v = 0; v < 4; v++) begin
            logic [7:0]  dv;
            logic [12:0] cw;
            dv = (v == 0) ? 8'h00 : (v == 1) ? 8'hA5 : (v == 2) ? 8'h3C : 8'hFF;
            cw = tb_enc(dv);
            ut_code = cw; #1;
            chk("R7 clean", ut_data, dv, ut_status, 2'b00);
            for (int b = 0; b < 13; b++) begin
                ut_code = cw ^ (13'd1 << b); #1;
                chk("R7 single", ut_data, dv, ut_status, 2'b01);
            end
            for (int b = 0; b < 12; b++) begin
                ut_code = cw ^ (13'd3 << b); #1;
                chk("R8 double", ut_data, tb_raw(cw ^ (13'd3 << b)), ut_status, 2'b10);
            end
        end

        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 port A", a_rdata, 8'h00, a_status, 2'b00);
        chk("R1 port B", b_rdata, 8'h00, b_status, 2'b00);
        rst_n = 1'b1;

        // R2: fill, A on even and B on odd addresses.
        for (int i = 0; i < 16; i += 2) begin
            step(AW'(i), 8'(i * 37 + 5), 1, 0, 0, AW'(i + 1), 8'(i * 91 + 12), 1, 0, "R2");
        end
        // R2, R5: cross read-back.
        for (int i = 0; i < 16; i++) begin
            step(AW'(i), 8'h00, 0, 1, 0, AW'(15 - i), 8'h00, 0, 1, "R5 R2");
        end
        // R4: hold with read enables low and junk on the inputs.
        step(4'd3, 8'hEE, 0, 0, 1, 4'd6, 8'hDD, 0, 0, "R4");
        idle();
        // R3: writes with enable low must not change the stored word.
        step(4'd3, 8'hFF, 0, 0, 1, 4'd6, 8'hFF, 0, 0, "R3");
        step(4'd3, 8'h00, 0, 1, 0, 4'd6, 8'h00, 0, 1, "R3");
        // R6: fault injection through port A.
        step(4'd5, 8'h96, 1, 0, 1, 4'd0, 8'h00, 0, 0, "R6");
        step(4'd5, 8'h00, 0, 1, 0, 4'd5, 8'h00, 0, 1, "R6");
        step(4'd5, 8'h96, 1, 1, 1, 4'd0, 8'h00, 0, 0, "R6");
        step(4'd5, 8'h69, 1, 0, 0, 4'd0, 8'h00, 0, 0, "R6");
        step(4'd5, 8'h00, 0, 1, 0, 4'd5, 8'h00, 0, 1, "R6");
        // R9: same-port read during write.
        step(4'd7, 8'h71, 1, 1, 0, 4'd8, 8'h82, 1, 1, "R9");
        step(4'd8, 8'h00, 0, 1, 0, 4'd7, 8'h00, 0, 1, "R9");
        // R10: mixed-port read during write returns old data.
        step(4'd2, 8'h5A, 1, 0, 0, 4'd2, 8'h00, 0, 1, "R10");
        step(4'd9, 8'h00, 0, 1, 0, 4'd9, 8'hC3, 1, 0, "R10");
        step(4'd9, 8'h00, 0, 1, 0, 4'd2, 8'h00, 0, 1, "R10");
        // R11: both ports write one address, A is stored.
        step(4'd4, 8'h11, 1, 1, 0, 4'd4, 8'h22, 1, 1, "R11");
        step(4'd4, 8'h00, 0, 1, 0, 4'd4, 8'h00, 0, 1, "R11");
        step(4'd12, 8'h3E, 1, 0, 1, 4'd12, 8'h44, 1, 0, "R11");
        step(4'd12, 8'h00, 0, 1, 0, 4'd12, 8'h00, 0, 1, "R11");
        idle();
        idle();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not finish, actual hung, expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule